// File: doc/BRIEF.md
# Stereo Serial Audio Transmit Port

This block is the transmit half of a serial audio port. Software or a DMA engine pushes stereo frames into a small buffer. Each frame holds two 16-bit samples, sample 0 in the low half and sample 1 in the high half. The port shifts the frames out MSB first on one data line, with a bit clock and a frame clock. Each frame lasts two slots, and each slot is as many bit clocks wide as a sample. With normal polarity, the left slot is the low phase of the frame clock. Data changes on the falling bit-clock edge and is stable on the rising edge.

Three framings can be selected: standard I2S, left-justified and right-justified. Either clock can be inverted on its pin, independently of the other. As clock master, the port toggles its own bit clock on each pulse of a divider enable and drives both clocks. As clock slave, it synchronizes an external bit clock and frame clock into its own clock domain. Each output slot has a map field that chooses which sample of the frame feeds it. The port runs only while both a global enable and a transmit enable are set. A flush input empties the buffer. A running counter tracks how many samples have been taken for transmission.

Top module: `stereo_tx_port`

## Requirements
- R1: `fmt` 0 and the reserved code 3 both select I2S framing: the data is delayed by one bit clock after each frame-clock edge, so the first bit of a slot carries the LSB of the previous slot. Codes 1 (left-justified) and 2 (right-justified) put the MSB in the first bit clock of the slot. Because a slot is exactly one sample wide, these two codes give identical streams.
- R2: A frame lasts 2×SW bit clocks. The left slot comes first, with the normalized frame clock low, and the right slot follows with it high. Each sample is sent MSB first.
- R3: `bclk_inv`=1 inverts the bit clock and `fclk_inv`=1 inverts the frame clock, on both the output and the input pins. All four combinations give the same data stream.
- R4: When `slave_mode`=0, the port drives both clocks (`clk_drive`=1) and toggles its bit clock once per `bclk_tick` pulse. When `slave_mode`=1, it follows `bclk_in` and `fclk_in`, drives `clk_drive`=0, and holds the clock outputs low.
- R5: The map field of each slot picks the sample that feeds it: value 0 picks sample 0, value 1 picks sample 1, and any other value sends zeros in that slot.
- R6: The port transmits only while `glb_en` and `tx_en` are both 1. While it is not transmitting, `sdata` is 0 and the bit clock stays at its idle level. While `glb_en` is 0, pushes are ignored.
- R7: `flush` empties the buffer and clears the underrun flag.
- R8: If the buffer is empty when a left slot starts, the whole frame is sent as zeros and the sticky `underrun` flag is set.
- R9: `tx_count` rises by 2 for every frame taken from the buffer. `cnt_clr` sets it to zero, and the clear wins over a take in the same cycle.
- R10: `buf_full` is 1 while DEPTH frames are held. `data_req` equals glb_en & tx_en & !buf_full.
- R11: After reset, `sdata`, `underrun`, `tx_count` and `buf_full` are 0. In master mode with no inversion, `bclk_out` is 0 and `fclk_out` is 1 (the right-slot level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| glb_en | input | 1 | Global enable |
| tx_en | input | 1 | Transmit enable |
| flush | input | 1 | Empty the buffer, clear underrun |
| fmt | input | 2 | Framing: 0/3 I2S, 1 left-justified, 2 right-justified |
| bclk_inv | input | 1 | Invert bit clock |
| fclk_inv | input | 1 | Invert frame clock |
| slave_mode | input | 1 | 1 = take clocks from outside |
| map_slot0 | input | 4 | Sample feeding the left slot |
| map_slot1 | input | 4 | Sample feeding the right slot |
| bclk_tick | input | 1 | Divider enable, one pulse per half bit clock |
| push_valid | input | 1 | Write a frame into the buffer |
| push_frame | input | 2*SW | {sample 1, sample 0} |
| bclk_in | input | 1 | External bit clock |
| fclk_in | input | 1 | External frame clock |
| cnt_clr | input | 1 | Clear the sample counter |
| data_req | output | 1 | Buffer can accept a frame while running |
| buf_full | output | 1 | Buffer holds DEPTH frames |
| bclk_out | output | 1 | Bit clock driven in master mode |
| fclk_out | output | 1 | Frame clock driven in master mode |
| clk_drive | output | 1 | Clock pins are driven by this port |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Sticky empty-at-frame-start flag |
| tx_count | output | CW | Samples taken for transmission |

## Verification
Two events can land in the same cycle: the frame-start take, which adds 2 to the sample counter, and a software counter clear. The bench drives the divider enable itself, so it knows exactly which pulse produces a falling bit-clock edge that opens a left slot. It raises `cnt_clr` together with that pulse. It then expects the counter to read zero while the frame's data still appears on the line. After one more frame, it expects the counter to read two.

// File: rtl/stereo_tx_port.sv
module stereo_tx_port #(
  parameter int SW    = 16,
  parameter int DEPTH = 4,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          glb_en,
  input  logic          tx_en,
  input  logic          flush,
  input  logic [1:0]    fmt,
  input  logic          bclk_inv,
  input  logic          fclk_inv,
  input  logic          slave_mode,
  input  logic [3:0]    map_slot0,
  input  logic [3:0]    map_slot1,
  input  logic          bclk_tick,
  input  logic          push_valid,
  input  logic [2*SW-1:0] push_frame,
  input  logic          bclk_in,
  input  logic          fclk_in,
  input  logic          cnt_clr,
  output logic          data_req,
  output logic          buf_full,
  output logic          bclk_out,
  output logic          fclk_out,
  output logic          clk_drive,
  output logic          sdata,
  output logic          underrun,
  output logic [CW-1:0] tx_count
);
  localparam int AW = $clog2(DEPTH);
  localparam int KW = $clog2(SW) + 1;

  logic active;
  assign active = glb_en & tx_en;

  // frame buffer
  logic [2*SW-1:0] mem [DEPTH];
  logic [AW:0] wptr, rptr;
  logic empty, take, start;
  assign empty    = (wptr == rptr);
  assign buf_full = ((wptr - rptr) == (AW+1)'(DEPTH));
  assign data_req = active & ~buf_full;

  always_ff @(posedge clk) begin
    if (push_valid && glb_en && !buf_full && !flush)
      mem[wptr[AW-1:0]] <= push_frame;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push_valid && glb_en && !buf_full) wptr <= wptr + 1'b1;
      if (take) rptr <= rptr + 1'b1;
    end
  end

  // clock generation / recovery
  logic       bck;
  logic [2:0] bsync;
  logic [1:0] fsync;
  logic       nb_now, nb_old, nf, ev;
  assign nb_now = bsync[1] ^ bclk_inv;
  assign nb_old = bsync[2] ^ bclk_inv;
  assign nf     = fsync[1] ^ fclk_inv;
  assign ev     = active & (slave_mode ? (nb_old & ~nb_now) : (bclk_tick & bck));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsync <= '0;
      fsync <= '0;
      bck   <= 1'b0;
    end else begin
      bsync <= {bsync[1:0], bclk_in};
      fsync <= {fsync[0], fclk_in};
      if (!active || slave_mode) bck <= 1'b0;
      else if (bclk_tick)        bck <= ~bck;
    end
  end

  // slot tracking
  logic [KW-1:0] k, nk;
  logic          slot, nslot;
  always_comb begin
    nk    = k;
    nslot = slot;
    if (slave_mode) begin
      if (nf != slot) begin
        nslot = nf;
        nk    = '0;
      end else if (k != KW'(SW)) begin
        nk = k + 1'b1;
      end
    end else if (k == KW'(SW-1)) begin
      nk    = '0;
      nslot = ~slot;
    end else begin
      nk = k + 1'b1;
    end
  end

  assign start = ev & ~nslot & (nk == '0);
  assign take  = start & ~empty;

  // sample selection through the channel map
  logic [SW-1:0] s0, s1, ld_l, ld_r, cur_l, cur_r, word, wsh;
  assign s0 = empty ? '0 : mem[rptr[AW-1:0]][SW-1:0];
  assign s1 = empty ? '0 : mem[rptr[AW-1:0]][2*SW-1:SW];
  assign ld_l = (map_slot0 == 4'd0) ? s0 : (map_slot0 == 4'd1) ? s1 : '0;
  assign ld_r = (map_slot1 == 4'd0) ? s0 : (map_slot1 == 4'd1) ? s1 : '0;
  assign word = nslot ? cur_r : (start ? ld_l : cur_l);
  assign wsh  = word << nk;

  logic lj_bit, i2s_bit, lj_next;
  assign lj_next = (nk < KW'(SW)) ? wsh[SW-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k       <= KW'(SW-1);
      slot    <= 1'b1;
      lj_bit  <= 1'b0;
      i2s_bit <= 1'b0;
      cur_l   <= '0;
      cur_r   <= '0;
    end else if (!active) begin
      k       <= KW'(SW-1);
      slot    <= 1'b1;
      lj_bit  <= 1'b0;
      i2s_bit <= 1'b0;
    end else if (ev) begin
      k       <= nk;
      slot    <= nslot;
      lj_bit  <= lj_next;
      i2s_bit <= lj_bit;
      if (start) begin
        cur_l <= ld_l;
        cur_r <= ld_r;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            underrun <= 1'b0;
    else if (flush)        underrun <= 1'b0;
    else if (start && empty) underrun <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tx_count <= '0;
    else if (cnt_clr) tx_count <= '0;
    else if (take)    tx_count <= tx_count + CW'(2);
  end

  assign sdata     = (fmt == 2'd1 || fmt == 2'd2) ? lj_bit : i2s_bit;
  assign clk_drive = ~slave_mode;
  assign bclk_out  = slave_mode ? 1'b0 : (bck ^ bclk_inv);
  assign fclk_out  = slave_mode ? 1'b0 : (slot ^ fclk_inv);

  assert_count_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (tx_count == '0));
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!buf_full && !underrun));
  assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !flush) |=> underrun);
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!lj_bit && !i2s_bit));
  assert_slot_only_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(ev)) |-> (slot == $past(slot)));
  assert_full_blocks_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && !take && !flush) |=> $stable(wptr));
endmodule

// File: tb/stereo_tx_port_tb.sv
module stereo_tx_port_tb;
  localparam int SW = 16;
  localparam int DEPTH = 4;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0;
  logic glb_en = 0, tx_en = 0, flush = 0, bclk_inv = 0, fclk_inv = 0, slave_mode = 0;
  logic [1:0] fmt = 2'd0;
  logic [3:0] map_slot0 = 4'd0, map_slot1 = 4'd1;
  logic bclk_tick = 0, push_valid = 0, bclk_in = 1, fclk_in = 1, cnt_clr = 0;
  logic [2*SW-1:0] push_frame = '0;
  logic data_req, buf_full, bclk_out, fclk_out, clk_drive, sdata, underrun;
  logic [CW-1:0] tx_count;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  stereo_tx_port #(.SW(SW), .DEPTH(DEPTH), .CW(CW)) u_dut (
    .clk, .rst_n, .glb_en, .tx_en, .flush, .fmt, .bclk_inv, .fclk_inv, .slave_mode,
    .map_slot0, .map_slot1, .bclk_tick, .push_valid, .push_frame, .bclk_in, .fclk_in,
    .cnt_clr, .data_req, .buf_full, .bclk_out, .fclk_out, .clk_drive, .sdata,
    .underrun, .tx_count);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    tx_en = 0; flush = 1; cnt_clr = 1; bclk_tick = 0; slave_mode = 0;
    bclk_inv = 0; fclk_inv = 0; map_slot0 = 0; map_slot1 = 1;
    bclk_in = 1; fclk_in = 1;
    @(negedge clk);
    flush = 0; cnt_clr = 0;
  endtask

  task automatic push(logic [15:0] s1, logic [15:0] s0);
    @(negedge clk);
    push_valid = 1; push_frame = {s1, s0};
    @(negedge clk);
    push_valid = 0;
  endtask

  task automatic step();
    @(negedge clk) bclk_tick = 1;
    @(negedge clk) bclk_tick = 0;
  endtask

  task automatic frame_m(output logic [31:0] bits, output logic [31:0] fck);
    for (int i = 0; i < 32; i++) begin
      step(); step();
      bits[31-i] = sdata;
      fck[31-i]  = fclk_out;
    end
  endtask

  task automatic frame_s(input logic inv_b, input logic inv_f, output logic [31:0] bits);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      bclk_in = inv_b;
      fclk_in = (i >= 16) ^ inv_f;
      repeat (4) @(negedge clk);
      bits[31-i] = sdata;
      bclk_in = ~inv_b;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R11 sdata", sdata, 0);
    check("R11 underrun", underrun, 0);
    check("R11 count", tx_count, 0);
    check("R11 full", buf_full, 0);
    check("R11 bclk", bclk_out, 0);
    check("R11 fclk", fclk_out, 1);
  endtask

  task automatic t_lj();
    logic [31:0] b, f;
    idle(); fmt = 2'd1; glb_en = 1;
    push(16'h1234, 16'hA5C3); push(16'h0F0F, 16'h8001);
    tx_en = 1;
    frame_m(b, f);
    check("R2 lj frame A", b, {16'hA5C3, 16'h1234});
    check("R2 fclk low left", f, 32'h0000FFFF);
    check("R4 master drive", clk_drive, 1);
    frame_m(b, f);
    check("R1 lj frame B", b, {16'h8001, 16'h0F0F});
    check("R9 count", tx_count, 4);
  endtask

  task automatic t_i2s(logic [1:0] code);
    logic [31:0] b, f;
    idle(); fmt = code; glb_en = 1;
    push(16'h1235, 16'hA5C3); push(16'h0F0F, 16'h8001);
    tx_en = 1;
    frame_m(b, f);
    check("R1 i2s frame A", b, {1'b0, 16'hA5C3, 15'h091A});
    frame_m(b, f);
    check("R1 i2s frame B", b, {1'b1, 16'h8001, 15'h0787});
  endtask

  task automatic t_rj();
    logic [31:0] b, f;
    idle(); fmt = 2'd2; glb_en = 1;
    push(16'h4321, 16'hC0DE);
    tx_en = 1;
    frame_m(b, f);
    check("R1 rj equals lj", b, {16'hC0DE, 16'h4321});
  endtask

  task automatic t_map();
    logic [31:0] b, f;
    idle(); fmt = 2'd1; glb_en = 1; map_slot0 = 1; map_slot1 = 0;
    push(16'hBEEF, 16'h1357);
    push(16'hBEEF, 16'h1357);
    tx_en = 1;
    frame_m(b, f);
    check("R5 swapped map", b, {16'hBEEF, 16'h1357});
    map_slot0 = 4'd5; map_slot1 = 4'd1;
    frame_m(b, f);
    check("R5 nonexistent sample silent", b, {16'h0000, 16'hBEEF});
  endtask

  task automatic t_polarity();
    logic [31:0] b, f;
    idle(); fmt = 2'd1; glb_en = 1; bclk_inv = 1; fclk_inv = 1;
    push(16'h00FF, 16'h7E81);
    tx_en = 1;
    check("R3 bclk idle inverted", bclk_out, 1);
    frame_m(b, f);
    check("R3 data unchanged", b, {16'h7E81, 16'h00FF});
    check("R3 fclk inverted", f, 32'hFFFF0000);
    check("R3 bclk after fall", bclk_out, 1);
  endtask

  task automatic t_underrun_flush();
    logic [31:0] b, f;
    idle(); fmt = 2'd1; glb_en = 1;
    push(16'hFFFF, 16'hFFFF); push(16'hFFFF, 16'hFFFF);
    flush = 1; @(negedge clk); flush = 0;
    tx_en = 1;
    frame_m(b, f);
    check("R7 flushed data gone", b, 0);
    check("R8 underrun set", underrun, 1);
    check("R9 no take on empty", tx_count, 0);
    tx_en = 0; flush = 1; @(negedge clk); flush = 0;
    check("R7 flush clears underrun", underrun, 0);
  endtask

  task automatic t_full();
    logic [31:0] b, f;
    idle(); fmt = 2'd1; glb_en = 1;
    for (int i = 0; i < DEPTH; i++) push(16'h1111, 16'h2222);
    check("R10 full", buf_full, 1);
    check("R10 no req when tx off", data_req, 0);
    tx_en = 1; @(negedge clk);
    check("R10 no req when full", data_req, 0);
    frame_m(b, f);
    check("R10 req after take", data_req, 1);
  endtask

  task automatic t_gating();
    logic [31:0] b, f;
    idle(); fmt = 2'd1; glb_en = 0;
    push(16'hAAAA, 16'h5555);
    glb_en = 1;
    step(); step();
    check("R6 no clock without tx_en", bclk_out, 0);
    tx_en = 1;
    frame_m(b, f);
    check("R6 push ignored without glb_en", {underrun, b}, {1'b1, 32'h0});
    push(16'hFFFF, 16'hFFFF);
    step(); step(); step();
    glb_en = 0;
    step();
    check("R6 global off quiet data", sdata, 0);
    check("R6 global off clock idle", bclk_out, 0);
  endtask

  task automatic t_slave();
    logic [31:0] b;
    idle(); fmt = 2'd1; glb_en = 1; slave_mode = 1;
    push(16'h6789, 16'hCAFE); push(16'h0123, 16'hFACE);
    tx_en = 1;
    frame_s(0, 0, b);
    check("R4 slave frame", b, {16'hCAFE, 16'h6789});
    check("R4 slave no drive", {clk_drive, bclk_out, fclk_out}, 0);
    tx_en = 0; @(negedge clk);
    bclk_inv = 1; fclk_inv = 1; bclk_in = 0; fclk_in = 0;
    repeat (4) @(negedge clk);
    tx_en = 1;
    frame_s(1, 1, b);
    check("R3 slave inverted clocks", b, {16'hFACE, 16'h0123});
  endtask

  task automatic t_clr_collide();
    logic [31:0] b, f;
    idle(); fmt = 2'd1; glb_en = 1;
    push(16'h0002, 16'h8000); push(16'h0004, 16'h4000);
    tx_en = 1;
    step();
    @(negedge clk) begin bclk_tick = 1; cnt_clr = 1; end
    @(negedge clk) begin bclk_tick = 0; cnt_clr = 0; end
    check("R9 clear wins over take", tx_count, 0);
    b[31] = sdata;
    for (int i = 1; i < 32; i++) begin
      step(); step();
      b[31-i] = sdata;
    end
    check("R9 frame still sent", b, {16'h8000, 16'h0002});
    frame_m(b, f);
    check("R9 count after next take", tx_count, 2);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_lj();
    t_i2s(2'd0);
    t_i2s(2'd3);
    t_rj();
    t_map();
    t_polarity();
    t_underrun_flush();
    t_full();
    t_gating();
    t_slave();
    t_clr_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule